// File: doc/BRIEF.md
# Self-Synchronizing Bit Descrambler

This block is the receive-side partner of a seven-stage additive bit scrambler. The scrambler's feedback is taken from stages 7 and 4, and its start value is a nonzero seed that changes from packet to packet. The receiver is never told that seed. The transmitter always sends seven zero payload bits at the head of each packet. Because of this, the first seven scrambled bits that arrive are exactly the transmitter's register contents once those bits have gone out.

The descrambler uses this fact directly. While the first seven bits of a packet arrive, it shifts each received bit into the low end of its own state register. From the eighth bit on, it runs the transmitter's feedback and XORs the feedback bit onto each received bit. It never buffers the warm-up bits and never solves for the seed. During warm-up it emits a zero for each bit and sets a flag on those beats.

Both streams use valid/ready handshakes:

- An input beat carries one scrambled bit and a start-of-packet marker. The beat transfers on a clock edge where `s_valid` and `s_ready` are both high.
- The output is a single register stage. `s_ready` is high whenever that stage is empty or is being drained in the same cycle. Back-pressure on `m_ready` therefore stalls the input directly, with no beat lost or repeated.
- A held output beat stays unchanged until it is taken.

Top module: `selfsync_descrambler`

## Requirements
- R1: After reset, `m_valid` is 0 and `s_ready` is 1.
- R2: An accepted beat with `s_sop`=1 is bit 0 of a new packet. That beat and the next six accepted beats each produce an output beat with `m_warm`=1 and `m_bit`=0.
- R3: During warm-up, the received bit is shifted into state stage 1. After warm-up, the state holds stage 7 = bit 0, stage 6 = bit 1, and so on down to stage 1 = bit 6.
- R4: From bit 7 onward, `m_warm`=0 and `m_bit` = stage7 XOR stage4 XOR received bit. At the same time, stage 1 takes stage7 XOR stage4 and the other stages shift up by one. For any nonzero seed in 1..127, this recovers the plaintext.
- R5: A start-of-packet beat that arrives before warm-up ends, or in the middle of a packet, restarts warm-up from bit 0.
- R6: While `m_valid`=1 and `m_ready`=0, the output beat (`m_valid`, `m_bit`, `m_warm`) holds steady on the next cycle.
- R7: `s_ready` equals (NOT `m_valid`) OR `m_ready`. Each accepted input beat yields exactly one output beat, in order. Cycles with `s_valid`=0 have no effect, whatever `s_sop` and `s_bit` carry.
- R8: An input beat accepted on one edge makes `m_valid`=1 right after that edge.
- R9: The warm-up count saturates. A packet of any length stays in descramble mode after its seventh bit until the next start-of-packet beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_sop | input | 1 | Beat is bit 0 of a packet |
| s_bit | input | 1 | Scrambled bit |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream can take the output beat |
| m_bit | output | 1 | Descrambled bit (0 during warm-up) |
| m_warm | output | 1 | Beat is one of the seven warm-up bits |

## Verification
The bench scrambles random payloads with random nonzero seeds and compares each output beat against a queue.

- A design that shifted the wrong tap, or fed the received bit into the register after warm-up, would show mismatching plaintext from bit 7 onward.
- A counter that started at the wrong value would mislabel the boundary beat.
- A counter that wrapped would drop long packets back into warm-up.

Other stimuli target the handshake:

- Truncated packets restarted mid-warm-up catch a counter that ignores a new start marker.
- Idle cycles carrying junk start markers catch a design that acts on an unqualified beat.
- Random back-pressure catches a lost, duplicated or changing output beat.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  typedef struct packed {
    logic warm;
    logic data;
  } dscr_beat_t;
endpackage

// File: rtl/dscr_warm_ctr.sv
module dscr_warm_ctr #(
  parameter int WARM_LEN = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic sop,
  output logic in_warm
);
  localparam int CNT_W = $clog2(WARM_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_LEN);

  logic [CNT_W-1:0] cnt_q;

  assign in_warm = sop || (cnt_q < LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      if (sop) begin
        cnt_q <= CNT_W'(1);
      end else if (cnt_q < LAST) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sop && !in_warm |=> cnt_q == LAST);

  // R2
  sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && sop |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/dscr_state_reg.sv
module dscr_state_reg #(
  parameter int STATE_W = 7,
  parameter int TAP_HI  = 7,
  parameter int TAP_LO  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic warm,
  input  logic rx_bit,
  output logic fb
);
  logic [STATE_W-1:0] st_q;
  logic               head;

  assign fb   = st_q[TAP_HI-1] ^ st_q[TAP_LO-1];
  assign head = warm ? rx_bit : fb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q[0] <= 1'b0;
    end else if (adv) begin
      st_q[0] <= head;
    end
  end

  for (genvar i = 1; i < STATE_W; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
      end else if (adv) begin
        st_q[i] <= st_q[i-1];
      end
    end
  end

  // R3
  warm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && warm |=> st_q[0] == $past(rx_bit));

  // R4
  run_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !warm |=> st_q[0] == ($past(st_q[TAP_HI-1]) ^ $past(st_q[TAP_LO-1])));
endmodule

// File: rtl/dscr_out_reg.sv
module dscr_out_reg
  import dscr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  dscr_beat_t in_beat,
  output logic       out_valid,
  input  logic       out_ready,
  output dscr_beat_t out_beat
);
  logic       vld_q;
  dscr_beat_t beat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_beat  = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= '0;
    end else if (in_valid && in_ready) begin
      vld_q  <= 1'b1;
      beat_q <= in_beat;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_beat));

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/selfsync_descrambler.sv
module selfsync_descrambler
  import dscr_pkg::*;
#(
  parameter int STATE_W = 7,
  parameter int TAP_HI  = 7,
  parameter int TAP_LO  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_sop,
  input  logic s_bit,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit,
  output logic m_warm
);
  localparam int WARM_LEN = STATE_W;

  logic       take;
  logic       in_warm;
  logic       fb;
  dscr_beat_t nxt_beat;
  dscr_beat_t cur_beat;

  assign take          = s_valid && s_ready;
  assign nxt_beat.warm = in_warm;
  assign nxt_beat.data = in_warm ? 1'b0 : (fb ^ s_bit);

  dscr_warm_ctr #(.WARM_LEN(WARM_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .take(take), .sop(s_sop), .in_warm(in_warm)
  );

  dscr_state_reg #(.STATE_W(STATE_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_state (
    .clk(clk), .rst_n(rst_n), .adv(take), .warm(in_warm), .rx_bit(s_bit), .fb(fb)
  );

  dscr_out_reg u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_beat(nxt_beat),
    .out_valid(m_valid), .out_ready(m_ready), .out_beat(cur_beat)
  );

  assign m_bit  = cur_beat.data;
  assign m_warm = cur_beat.warm;

  // R2
  sop_warm_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && s_sop |=> m_warm && !m_bit);

  // R7
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_valid && !s_valid |=> !m_valid);
endmodule

// File: tb/selfsync_descrambler_tb.sv
module selfsync_descrambler_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_sop = 1'b0;
  logic s_bit = 1'b0;
  logic m_ready = 1'b0;
  logic s_ready, m_valid, m_bit, m_warm;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] exp_q[$];
  bit rdy_always = 1'b0;
  bit gaps_on = 1'b0;
  bit lat_chk = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  selfsync_descrambler u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sop(s_sop), .s_bit(s_bit), .m_valid(m_valid), .m_ready(m_ready),
    .m_bit(m_bit), .m_warm(m_warm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_beat(input logic sop, input logic b);
    bit took = 1'b0;
    while (!took) begin
      @(negedge clk);
      if (gaps_on && $urandom_range(0, 3) == 0) begin
        // R7: junk on idle cycles
        s_valid = 1'b0;
        s_sop = 1'($urandom_range(0, 1));
        s_bit = 1'($urandom_range(0, 1));
      end else begin
        s_valid = 1'b1;
        s_sop = sop;
        s_bit = b;
        #2;
        if (s_ready) took = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    s_valid = 1'b0;
    if (lat_chk) begin
      @(negedge clk);
      check(m_valid === 1'b1, "R8", int'(m_valid), 1);
    end
  endtask

  task automatic send_packet(input int n, input logic [6:0] seed);
    logic [7:1] st;
    st = seed;
    for (int i = 0; i < n; i++) begin
      logic p, f, sb;
      p = (i < 7) ? 1'b0 : 1'($urandom_range(0, 1));
      f = st[7] ^ st[4];
      sb = f ^ p;
      st = {st[6:1], f};
      exp_q.push_back({(i < 7) ? 1'b1 : 1'b0, p});
      send_beat(i == 0, sb);
    end
  endtask

  initial begin : monitor
    logic stall_prev = 1'b0;
    logic [1:0] held = 2'b00;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        m_ready = rdy_always ? 1'b1 : ($urandom_range(0, 2) != 0);
        if (stall_prev) begin
          // R6
          check(m_valid === 1'b1 && {m_warm, m_bit} === held, "R6",
                int'({m_valid, m_warm, m_bit}), int'({1'b1, held}));
        end
        if (m_valid && m_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected beat", int'({m_warm, m_bit}), -1);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            // R2 R3 R4 R5 R9
            check({m_warm, m_bit} === e, e[1] ? "R2/R5 warm" : "R3/R4/R9 data",
                  int'({m_warm, m_bit}), int'(e));
          end
        end
        stall_prev = m_valid && !m_ready;
        held = {m_warm, m_bit};
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(m_valid === 1'b0, "R1 m_valid", int'(m_valid), 0);
    check(s_ready === 1'b1, "R1 s_ready", int'(s_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R8: steady ready, latency
    rdy_always = 1'b1;
    lat_chk = 1'b1;
    send_packet(12, 7'd1);
    lat_chk = 1'b0;

    // R4: several seeds, back-pressure and gaps (R6, R7)
    rdy_always = 1'b0;
    gaps_on = 1'b1;
    send_packet(20, 7'd127);
    send_packet(16, 7'h55);
    for (int k = 0; k < 20; k++) begin
      send_packet($urandom_range(8, 40), 7'($urandom_range(1, 127)));
    end

    // R5: truncated packets restarted inside warm-up
    send_packet(4, 7'h2a);
    send_packet(1, 7'h11);
    send_packet(6, 7'h3c);
    send_packet(15, 7'h64);
    // R5: restart in the middle of descramble mode
    send_packet(10, 7'h0f);
    send_packet(12, 7'h71);

    // R9: long packet
    send_packet(300, 7'h5a);

    gaps_on = 1'b0;
    rdy_always = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    // R7: all beats delivered, none extra
    check(exp_q.size() == 0, "R7 drained", exp_q.size(), 0);
    check(m_valid === 1'b0, "R7 idle", int'(m_valid), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule